// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates sixteen interrupt request lines for a small CPU core. Each line goes through an edge detector that records a rising transition in a pending bit, whether or not that line is currently enabled. The pending bits are qualified by per-line enable bits and by a global enable flag that the core sets and clears with its enable and disable instructions. Line 15 bypasses both kinds of gating. The highest-numbered qualified line wins. Two special requests, a software trap and an unimplemented-opcode fault, sit above every numbered line.

The core sees a request flag that is derived combinationally from the arbitration result. When the core acknowledges at an instruction boundary, the controller captures the winner and clears its pending state. It then counts out the vector-generation latency, which is 11 cycles with an internal stack and 13 with an external one. At the end of that count it presents the 16-bit vector address with a one-cycle valid strobe.

Certain retired instructions (the enable/disable and the stack save/restore instructions) open a window that lasts one further instruction. Numbered lines are not offered during that window. A small register port lets software read and overwrite the pending and enable registers.

Top module: `pvic_top`

## Requirements
- R1: A rising edge on `req_in[n]` sets pending bit n one cycle later, even when enable bit n is 0. A line held high sets the bit only once, so after software clears the bit it stays clear.
- R2: When several lines qualify, the highest-numbered one wins. Line 15 qualifies from its pending bit alone, regardless of its enable bit or the global enable.
- R3: Lines 0 to 14 qualify only when their pending bit, their enable bit and the global enable are all 1. `cmd_gie_set` sets the global enable and `cmd_gie_clr` clears it. If both are pulsed in the same cycle, the clear wins. The global enable is 0 after reset.
- R4: Line n in 0..7 produces vector 16'h2000 + 2·n. Line n in 8..15 produces vector 16'h2030 + 2·(n−8).
- R5: An accepted acknowledge clears the winner's pending bit and leaves every other pending bit unchanged.
- R6: A pulse on `instr_retire` with `retire_inhibit`=1 blocks all numbered lines. `irq` stays 0 for numbered lines until a later `instr_retire` with `retire_inhibit`=0.
- R7: A `trap_req` pulse is latched and served at vector 16'h2010. An `unimp_req` pulse is latched and served at vector 16'h2012. Neither is gated by the enables or by the inhibit window. The unimplemented-opcode request wins over the trap, and the trap wins over line 15.
- R8: If `ack` is accepted at clock edge E, `vec_valid` is 1 only in the cycle that follows edge E+L−1. L is 11, or 13 when `ext_stack` is 1 at edge E. `vec_addr` then holds the winner's vector.
- R9: From the accepted acknowledge until the vector has been delivered, `irq` is 0 and further `ack` pulses are ignored.
- R10: With `reg_wr`=1 at a clock edge, `reg_sel`=0 loads `reg_wdata` into the pending register and `reg_sel`=1 loads it into the enable register. `reg_rdata` shows the pending register when `reg_sel`=0 and the enable register when `reg_sel`=1.
- R11: After reset, the pending and enable registers read 0, and both `irq` and `vec_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 16 | Interrupt request lines, edge detected |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wdata | input | 16 | Register port write data |
| reg_rdata | output | 16 | Register port read data |
| cmd_gie_set | input | 1 | Global enable set command |
| cmd_gie_clr | input | 1 | Global enable clear command |
| instr_retire | input | 1 | Instruction completed strobe |
| retire_inhibit | input | 1 | Retiring instruction opens the inhibit window |
| trap_req | input | 1 | Software trap request pulse |
| unimp_req | input | 1 | Unimplemented-opcode request pulse |
| ack | input | 1 | Core acknowledge at an instruction boundary |
| ext_stack | input | 1 | Selects the long vector latency |
| irq | output | 1 | Service request to the core |
| vec_addr | output | 16 | Vector address of the served request |
| vec_valid | output | 1 | One-cycle strobe marking vec_addr valid |

## Verification
On every cycle, the assertions check that:
- an edge always reaches its pending bit;
- no request is raised while a vector is in flight or while the inhibit window is open;
- every accepted numbered line below 15 had its enables set;
- the valid strobe lasts one cycle and never follows an acknowledge directly;
- the captured vector does not change while it is in flight.

Only the bench scenarios can show behaviour that depends on values. This covers the exact address map and which line wins a given pending/enable mix. It also covers the precise 11- and 13-cycle latencies, the ordering of the unimplemented-opcode request, the trap and line 15, the clear-wins rule for the global enable, and the fact that a held line does not re-arm.

// File: rtl/pvic_pkg.sv
`timescale 1ns/1ps
package pvic_pkg;

    localparam int NSRC = 16;
    localparam int IDW  = $clog2(NSRC);
    localparam int VW   = 16;
    localparam int HALF = NSRC / 2;

    localparam logic [VW-1:0] VBASE_LO  = 16'h2000;
    localparam logic [VW-1:0] VBASE_HI  = 16'h2030;
    localparam logic [VW-1:0] VEC_TRAP  = 16'h2010;
    localparam logic [VW-1:0] VEC_UNIMP = 16'h2012;

    typedef enum logic [1:0] {
        W_NONE  = 2'd0,
        W_LINE  = 2'd1,
        W_TRAP  = 2'd2,
        W_UNIMP = 2'd3
    } win_kind_e;

    typedef struct packed {
        win_kind_e      kind;
        logic [IDW-1:0] idx;
    } winner_t;

    // Vector address of a winner: two banks of two-byte slots
    function automatic logic [VW-1:0] vec_of(input winner_t w);
        logic [VW-1:0] off;
        off = VW'({w.idx[IDW-2:0], 1'b0});
        case (w.kind)
            W_UNIMP: vec_of = VEC_UNIMP;
            W_TRAP:  vec_of = VEC_TRAP;
            W_LINE:  vec_of = (int'(w.idx) >= HALF) ? VBASE_HI + off : VBASE_LO + off;
            default: vec_of = '0;
        endcase
    endfunction

endpackage

// File: rtl/pvic_pend_bank.sv
`timescale 1ns/1ps
module pvic_pend_bank
    import pvic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req_in,
    input  logic         wr_pend,
    input  logic         wr_mask,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] pend,
    output logic [N-1:0] mask
);

    logic [N-1:0] req_q;
    logic [N-1:0] rise;
    logic [N-1:0] base;
    logic [N-1:0] pend_nx;

    always_comb begin
        rise    = req_in & ~req_q;
        base    = wr_pend ? wdata : pend;
        pend_nx = (base & ~clr_vec) | rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            pend  <= '0;
            mask  <= '0;
        end else begin
            req_q <= req_in;
            pend  <= pend_nx;
            if (wr_mask) mask <= wdata;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> pend[i]); // R1
    end

endmodule

// File: rtl/pvic_arbiter.sv
`timescale 1ns/1ps
module pvic_arbiter
    import pvic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic         gie,
    input  logic         inhibit,
    input  logic         trap_p,
    input  logic         unimp_p,
    output winner_t      win
);

    logic [N-1:0] ready;

    always_comb begin
        ready        = pend & (gie ? mask : '0);
        ready[N-1]   = pend[N-1];
        if (inhibit) ready = '0;

        win.kind = W_NONE;
        win.idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (ready[i]) begin
                win.kind = W_LINE;
                win.idx  = IDW'(i);
            end
        end
        if (trap_p) begin
            win.kind = W_TRAP;
            win.idx  = '0;
        end
        if (unimp_p) begin
            win.kind = W_UNIMP;
            win.idx  = '0;
        end
    end

endmodule

// File: rtl/pvic_vec_seq.sv
`timescale 1ns/1ps
module pvic_vec_seq
    import pvic_pkg::*;
#(
    parameter int LAT_INT = 11,
    parameter int LAT_EXT = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          ext_stack,
    input  logic [VW-1:0] vec_in,
    output logic          busy,
    output logic          vec_valid,
    output logic [VW-1:0] vec_addr
);

    localparam int CW = $clog2(LAT_EXT + 1);
    localparam logic [CW-1:0] LOAD_INT = CW'(LAT_INT - 1);
    localparam logic [CW-1:0] LOAD_EXT = CW'(LAT_EXT - 1);

    logic [CW-1:0] cnt;
    logic [VW-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            vec_q <= '0;
        end else if (take && !busy) begin
            busy  <= 1'b1;
            cnt   <= ext_stack ? LOAD_EXT : LOAD_INT;
            vec_q <= vec_in;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign vec_valid = busy && (cnt == '0);
    assign vec_addr  = vec_q;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid); // R8
    AST_NO_INSTANT_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (take && !busy) |=> !vec_valid); // R8
    AST_VECTOR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(vec_q)); // R8

endmodule

// File: rtl/pvic_top.sv
`timescale 1ns/1ps
module pvic_top
    import pvic_pkg::*;
#(
    parameter int LAT_INT = 11,
    parameter int LAT_EXT = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_in,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [NSRC-1:0] reg_wdata,
    output logic [NSRC-1:0] reg_rdata,
    input  logic            cmd_gie_set,
    input  logic            cmd_gie_clr,
    input  logic            instr_retire,
    input  logic            retire_inhibit,
    input  logic            trap_req,
    input  logic            unimp_req,
    input  logic            ack,
    input  logic            ext_stack,
    output logic            irq,
    output logic [VW-1:0]   vec_addr,
    output logic            vec_valid
);

    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] clr_vec;
    logic            gie_q;
    logic            inhibit_q;
    logic            trap_p;
    logic            unimp_p;
    logic            busy;
    logic            take;
    winner_t         win;

    pvic_pend_bank #(.N(NSRC)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .req_in  (req_in),
        .wr_pend (reg_wr && !reg_sel),
        .wr_mask (reg_wr && reg_sel),
        .wdata   (reg_wdata),
        .clr_vec (clr_vec),
        .pend    (pend),
        .mask    (mask)
    );

    pvic_arbiter #(.N(NSRC)) u_arb (
        .pend    (pend),
        .mask    (mask),
        .gie     (gie_q),
        .inhibit (inhibit_q),
        .trap_p  (trap_p),
        .unimp_p (unimp_p),
        .win     (win)
    );

    pvic_vec_seq #(.LAT_INT(LAT_INT), .LAT_EXT(LAT_EXT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .ext_stack (ext_stack),
        .vec_in    (vec_of(win)),
        .busy      (busy),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr)
    );

    assign irq       = (win.kind != W_NONE) && !busy;
    assign take      = ack && irq;
    assign reg_rdata = reg_sel ? mask : pend;

    always_comb begin
        clr_vec = '0;
        if (take && win.kind == W_LINE) clr_vec[win.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q     <= 1'b0;
            inhibit_q <= 1'b0;
            trap_p    <= 1'b0;
            unimp_p   <= 1'b0;
        end else begin
            if (cmd_gie_clr)      gie_q <= 1'b0;
            else if (cmd_gie_set) gie_q <= 1'b1;
            if (instr_retire) inhibit_q <= retire_inhibit;
            trap_p  <= trap_req  || (trap_p  && !(take && win.kind == W_TRAP));
            unimp_p <= unimp_req || (unimp_p && !(take && win.kind == W_UNIMP));
        end
    end

    AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !irq); // R9
    AST_INHIBIT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (inhibit_q && !trap_p && !unimp_p) |-> !irq); // R6
    AST_GATED_TAKE: assert property (@(posedge clk) disable iff (rst)
        (take && win.kind == W_LINE && win.idx != IDW'(NSRC - 1)) |-> (gie_q && mask[win.idx])); // R3
    AST_SPECIAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (take && win.kind == W_UNIMP && !unimp_req) |=> !unimp_p); // R7

endmodule

// File: tb/pvic_top_bench.sv
`timescale 1ns/1ps
module pvic_top_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req_in = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cmd_gie_set = 1'b0;
    logic        cmd_gie_clr = 1'b0;
    logic        instr_retire = 1'b0;
    logic        retire_inhibit = 1'b0;
    logic        trap_req = 1'b0;
    logic        unimp_req = 1'b0;
    logic        ack = 1'b0;
    logic        ext_stack = 1'b0;
    logic        irq;
    logic [15:0] vec_addr;
    logic        vec_valid;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pvic_top u_pvic_top (
        .clk(clk), .rst(rst), .req_in(req_in),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_gie_set(cmd_gie_set), .cmd_gie_clr(cmd_gie_clr),
        .instr_retire(instr_retire), .retire_inhibit(retire_inhibit),
        .trap_req(trap_req), .unimp_req(unimp_req),
        .ack(ack), .ext_stack(ext_stack),
        .irq(irq), .vec_addr(vec_addr), .vec_valid(vec_valid)
    );

    // {pending, enable, gie, expect irq, expect vector}
    localparam int NV = 10;
    localparam logic [49:0] TBL [NV] = '{
        {16'h0001, 16'h0001, 1'b1, 1'b1, 16'h2000},
        {16'h0081, 16'hFFFF, 1'b1, 1'b1, 16'h200E},
        {16'h0300, 16'hFFFF, 1'b1, 1'b1, 16'h2032},
        {16'h8001, 16'h0000, 1'b0, 1'b1, 16'h203E},
        {16'h4000, 16'h0000, 1'b1, 1'b0, 16'h0000},
        {16'h4000, 16'h4000, 1'b0, 1'b0, 16'h0000},
        {16'h7FFF, 16'h3FFF, 1'b1, 1'b1, 16'h203A},
        {16'h0100, 16'h0100, 1'b1, 1'b1, 16'h2030},
        {16'h0400, 16'h0500, 1'b1, 1'b1, 16'h2034},
        {16'h0000, 16'hFFFF, 1'b1, 1'b0, 16'h0000}
    };

    always @(posedge clk) begin
        if (!done) begin
            cyc <= cyc + 1;
            if (cyc == 100000) begin
                $display("FAIL watchdog: actual hung, expected completion");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
                $finish;
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic gie(input logic set, input logic clr);
        @(negedge clk);
        cmd_gie_set = set; cmd_gie_clr = clr;
        @(negedge clk);
        cmd_gie_set = 1'b0; cmd_gie_clr = 1'b0;
    endtask

    task automatic retire(input logic inh);
        @(negedge clk);
        instr_retire = 1'b1; retire_inhibit = inh;
        @(negedge clk);
        instr_retire = 1'b0; retire_inhibit = 1'b0;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, {15'b0, irq}, {15'b0, exp});
    endtask

    task automatic do_ack(input logic [15:0] exp, input int lat, input logic ext,
                          input logic hold, input string tag);
        @(negedge clk);
        ack = 1'b1; ext_stack = ext;
        @(posedge clk);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            if (k == 1 && !hold) ack = 1'b0;
            if (k == 2) chk("R9 irq while busy", {15'b0, irq}, 16'h0);
            if (k == lat - 1) begin
                ack = 1'b0;
                chk({tag, " R8 early valid"}, {15'b0, vec_valid}, 16'h0);
            end
            if (k == lat) begin
                chk({tag, " R8 valid"}, {15'b0, vec_valid}, 16'h1);
                chk({tag, " R4 vector"}, vec_addr, exp);
            end
        end
        ext_stack = 1'b0;
        @(negedge clk);
        chk({tag, " R8 valid drop"}, {15'b0, vec_valid}, 16'h0);
    endtask

    function automatic int idx_of(input logic [15:0] a);
        if (a >= 16'h2030) return 8 + int'((a - 16'h2030) >> 1);
        return int'((a - 16'h2000) >> 1);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        chk("R11 irq", {15'b0, irq}, 16'h0);
        chk("R11 vec_valid", {15'b0, vec_valid}, 16'h0);
        rd(1'b0, 16'h0000, "R11 pending");
        rd(1'b1, 16'h0000, "R11 enable");

        // R2 R3 R4 R5: table walk
        for (int v = 0; v < NV; v++) begin
            logic [15:0] p, m, a;
            logic g, e;
            {p, m, g, e, a} = TBL[v];
            wr(1'b0, p);
            wr(1'b1, m);
            if (g) gie(1'b1, 1'b0); else gie(1'b0, 1'b1);
            check_irq(e, "R2/R3 table irq");
            if (e) begin
                do_ack(a, 11, 1'b0, 1'b0, "table");
                rd(1'b0, p & ~(16'h1 << idx_of(a)), "R5 pending after ack");
            end
            wr(1'b0, 16'h0000);
        end

        // R1 edge latches while disabled; held level does not re-arm
        wr(1'b1, 16'h0000);
        @(negedge clk); req_in[3] = 1'b1;
        @(negedge clk);
        rd(1'b0, 16'h0008, "R1 edge sets pending");
        wr(1'b0, 16'h0000);
        repeat (3) @(negedge clk);
        rd(1'b0, 16'h0000, "R1 held level no re-arm");
        req_in[3] = 1'b0;

        // R10 register port
        wr(1'b1, 16'hA5C3);
        rd(1'b1, 16'hA5C3, "R10 enable readback");
        wr(1'b0, 16'h1234);
        rd(1'b0, 16'h1234, "R10 pending write");
        wr(1'b0, 16'h0000);

        // R3 clear wins over set
        wr(1'b0, 16'h0010);
        wr(1'b1, 16'h0010);
        gie(1'b1, 1'b0);
        check_irq(1'b1, "R3 enabled line");
        gie(1'b1, 1'b1);
        check_irq(1'b0, "R3 clear wins");
        wr(1'b0, 16'h0000);

        // R6 inhibit window
        wr(1'b0, 16'h0004);
        wr(1'b1, 16'h0004);
        gie(1'b1, 1'b0);
        check_irq(1'b1, "R6 before window");
        retire(1'b1);
        check_irq(1'b0, "R6 window open");
        check_irq(1'b0, "R6 window still open");
        retire(1'b0);
        check_irq(1'b1, "R6 window closed");
        do_ack(16'h2004, 11, 1'b0, 1'b0, "R6 line2");

        // R8 long latency, R9 ack held during busy is ignored
        wr(1'b1, 16'hFFFF);
        wr(1'b0, 16'h0022);
        do_ack(16'h200A, 13, 1'b1, 1'b1, "R8 ext stack");
        rd(1'b0, 16'h0002, "R9 held ack ignored");
        do_ack(16'h2002, 11, 1'b0, 1'b0, "R9 next line");

        // R7 specials, ungated, ordered above line 15
        gie(1'b0, 1'b1);
        wr(1'b1, 16'h0000);
        @(negedge clk); trap_req = 1'b1;
        @(negedge clk); trap_req = 1'b0;
        check_irq(1'b1, "R7 trap irq with enables off");
        do_ack(16'h2010, 11, 1'b0, 1'b0, "R7 trap");
        wr(1'b0, 16'h8000);
        @(negedge clk); trap_req = 1'b1; unimp_req = 1'b1;
        @(negedge clk); trap_req = 1'b0; unimp_req = 1'b0;
        do_ack(16'h2012, 11, 1'b0, 1'b0, "R7 unimp first");
        do_ack(16'h2010, 11, 1'b0, 1'b0, "R7 trap second");
        do_ack(16'h203E, 11, 1'b0, 1'b0, "R7 line15 last");
        check_irq(1'b0, "R7 all served");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

endmodule